// File: doc/BRIEF.md
# Core-Presence Snoop Filter for an Inclusive Shared Cache

This block decides which private core caches must be snooped when a request reaches a shared, inclusive last-level cache. For every way of every set it keeps a presence vector holding one bit per core. A set bit means the core may hold the line. A clear bit means the core certainly does not. Because the shared cache is inclusive, a lookup miss proves that no core holds the line. On a hit, only the cores whose bits are set need a snoop.

The shared-cache controller presents each request together with its own lookup result. The request carries the requesting core, the set, the way (the hit way, or the way chosen for the fill), and whether it is a plain read or a read-for-ownership. One cycle later the block returns:
- the snoop-target mask;
- a hint that the line cannot be modified in any core.

The presence vectors are updated in the same cycle as the request:
- on a fill;
- on a shared-cache victim eviction, which also produces a back-invalidate mask that keeps the caches inclusive;
- when a core reports that it silently dropped a line.

Top module: `cv_snoop_filter`

## Requirements
- R1: After reset every presence vector is zero and rsp_valid, snoop_mask, no_mod_hint, binv_valid and binv_mask are all low. A hit request issued right after reset therefore snoops no core.
- R2: rsp_valid is high exactly in the cycle after req_valid was high. In any other cycle rsp_valid, snoop_mask and no_mod_hint are low.
- R3: A request with lookup_hit low returns snoop_mask zero and no_mod_hint high. The vector of the addressed set/way becomes the requester's bit alone (a fill).
- R4: A request with lookup_hit high returns snoop_mask equal to the stored vector with the requester's bit cleared. Bit i of every core mask stands for core i.
- R5: no_mod_hint is high on a hit when the stored vector has zero bits set or two or more bits set, and low when exactly one bit is set.
- R6: A read hit (req_own = 0) adds the requester's bit and keeps all other bits.
- R7: A read-for-ownership hit (req_own = 1) leaves only the requester's bit set.
- R8: evict_valid makes binv_valid high in the next cycle, with binv_mask equal to the evicted entry's vector, and clears that vector. With no eviction, binv_valid and binv_mask are low.
- R9: drop_valid clears only the named core's bit of the addressed entry.
- R10: When several updates address the same entry in one cycle, the outputs reflect the vector held before that cycle. The request update is applied first, then the core drop, and a shared-cache eviction overrides both and leaves the vector zero.
- R11: An update changes only the addressed set/way. Every other entry keeps its vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_core | input | 2 | Requesting core number |
| req_set | input | 3 | Set index of the request |
| req_way | input | 4 | Hit way, or way being filled on a miss |
| req_own | input | 1 | 1 = read-for-ownership, 0 = read |
| lookup_hit | input | 1 | Shared-cache lookup result for the request |
| evict_valid | input | 1 | Shared-cache victim leaves this cycle |
| evict_set | input | 3 | Set of the victim |
| evict_way | input | 4 | Way of the victim |
| drop_valid | input | 1 | A core reports it no longer holds a line |
| drop_core | input | 2 | Core that dropped the line |
| drop_set | input | 3 | Set of the dropped line |
| drop_way | input | 4 | Way of the dropped line |
| rsp_valid | output | 1 | Snoop decision valid |
| snoop_mask | output | 4 | Cores to snoop, bit i = core i |
| no_mod_hint | output | 1 | Line cannot be modified in any core |
| binv_valid | output | 1 | Back-invalidate decision valid |
| binv_mask | output | 4 | Cores to back-invalidate, bit i = core i |

## Verification
Some properties hold on every cycle, and the assertions check them:
- response and back-invalidate timing, including quiet outputs when nothing was requested;
- empty masks on a lookup miss;
- the requester never appearing in its own mask;
- the hint being raised whenever two or more other cores are targeted;
- the back-invalidate mask matching the entry that was read.

Other behaviour depends on history, so only the bench scenarios can show it, by comparing against a per-core presence model:
- bits accumulating across read hits;
- ownership collapsing a vector;
- drops and evictions clearing state;
- same-cycle update ordering;
- isolation between entries.

// File: rtl/sf_pkg.sv
package sf_pkg;
  localparam int unsigned SF_CORES = 4;
  localparam int unsigned SF_CID_W = $clog2(SF_CORES);

  typedef logic [SF_CORES-1:0] cv_t;
  typedef logic [SF_CID_W-1:0] cid_t;

  // Bit of a single core in a presence vector.
  function automatic cv_t cv_onehot(cid_t c);
    cv_t v;
    v = '0;
    v[c] = 1'b1;
    return v;
  endfunction

  // Cores that must be snooped: nobody on a miss, never the requester.
  function automatic cv_t cv_snoop_targets(cv_t v, logic hit, cid_t c);
    cv_t t;
    if (hit) t = v & ~cv_onehot(c);
    else     t = '0;
    return t;
  endfunction

  // A miss, an empty vector, or two or more holders rule out a modified copy.
  function automatic logic cv_not_modified(cv_t v, logic hit);
    logic nm;
    if (!hit) nm = 1'b1;
    else      nm = ($countones(v) != 1);
    return nm;
  endfunction

  // Vector after a request: fill or ownership gives the requester alone,
  // a read hit adds the requester.
  function automatic cv_t cv_after_req(cv_t v, cid_t c, logic own, logic hit);
    cv_t n;
    if (!hit || own) n = cv_onehot(c);
    else             n = v | cv_onehot(c);
    return n;
  endfunction

  // Vector after a core reports it dropped the line.
  function automatic cv_t cv_after_drop(cv_t v, cid_t c);
    return v & ~cv_onehot(c);
  endfunction
endpackage

// File: rtl/sf_vec_array.sv
module sf_vec_array
  import sf_pkg::*;
#(
  parameter int unsigned ENTRIES = 128,
  parameter int unsigned IDX_W   = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [IDX_W-1:0] req_idx,
  input  cid_t             req_core,
  input  logic             req_own,
  input  logic             req_hit,
  input  logic             drop_valid,
  input  logic [IDX_W-1:0] drop_idx,
  input  cid_t             drop_core,
  input  logic             ev_valid,
  input  logic [IDX_W-1:0] ev_idx,
  output cv_t              req_rd,
  output cv_t              ev_rd
);
  cv_t vec_all [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    cv_t  q;
    cv_t  nxt;
    logic sel_req;
    logic sel_drop;
    logic sel_ev;

    assign sel_req  = req_valid  && (req_idx  == IDX_W'(e));
    assign sel_drop = drop_valid && (drop_idx == IDX_W'(e));
    assign sel_ev   = ev_valid   && (ev_idx   == IDX_W'(e));

    // Fixed order: request, then drop, eviction last.
    always_comb begin
      nxt = q;
      if (sel_req)  nxt = cv_after_req(nxt, req_core, req_own, req_hit);
      if (sel_drop) nxt = cv_after_drop(nxt, drop_core);
      if (sel_ev)   nxt = '0;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else        q <= nxt;
    end

    assign vec_all[e] = q;
  end

  assign req_rd = vec_all[req_idx];
  assign ev_rd  = vec_all[ev_idx];
endmodule

// File: rtl/sf_req_path.sv
module sf_req_path
  import sf_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  cid_t req_core,
  input  logic req_hit,
  input  cv_t  cur_vec,
  output logic rsp_valid,
  output cv_t  snoop_mask,
  output logic no_mod_hint
);
  cv_t  mask_d;
  logic hint_d;

  always_comb begin
    mask_d = '0;
    hint_d = 1'b0;
    if (req_valid) begin
      mask_d = cv_snoop_targets(cur_vec, req_hit, req_core);
      hint_d = cv_not_modified(cur_vec, req_hit);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      snoop_mask  <= '0;
      no_mod_hint <= 1'b0;
    end else begin
      rsp_valid   <= req_valid;
      snoop_mask  <= mask_d;
      no_mod_hint <= hint_d;
    end
  end
endmodule

// File: rtl/sf_binv_path.sv
module sf_binv_path
  import sf_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ev_valid,
  input  cv_t  ev_vec,
  output logic binv_valid,
  output cv_t  binv_mask
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      binv_valid <= 1'b0;
      binv_mask  <= '0;
    end else begin
      binv_valid <= ev_valid;
      binv_mask  <= ev_valid ? ev_vec : '0;
    end
  end
endmodule

// File: rtl/cv_snoop_filter.sv
module cv_snoop_filter
  import sf_pkg::*;
#(
  parameter int unsigned SETS = 8,
  parameter int unsigned WAYS = 16,
  localparam int unsigned SET_W = $clog2(SETS),
  localparam int unsigned WAY_W = $clog2(WAYS),
  localparam int unsigned CID_W = SF_CID_W,
  localparam int unsigned NC    = SF_CORES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [CID_W-1:0] req_core,
  input  logic [SET_W-1:0] req_set,
  input  logic [WAY_W-1:0] req_way,
  input  logic             req_own,
  input  logic             lookup_hit,
  input  logic             evict_valid,
  input  logic [SET_W-1:0] evict_set,
  input  logic [WAY_W-1:0] evict_way,
  input  logic             drop_valid,
  input  logic [CID_W-1:0] drop_core,
  input  logic [SET_W-1:0] drop_set,
  input  logic [WAY_W-1:0] drop_way,
  output logic             rsp_valid,
  output logic [NC-1:0]    snoop_mask,
  output logic             no_mod_hint,
  output logic             binv_valid,
  output logic [NC-1:0]    binv_mask
);
  // SETS and WAYS are powers of two, so {set, way} indexes the array densely.
  localparam int unsigned ENTRIES = SETS * WAYS;
  localparam int unsigned IDX_W   = SET_W + WAY_W;

  logic [IDX_W-1:0] req_idx;
  logic [IDX_W-1:0] ev_idx;
  logic [IDX_W-1:0] drop_idx;
  cv_t              req_rd_vec;
  cv_t              ev_rd_vec;

  assign req_idx  = {req_set,   req_way};
  assign ev_idx   = {evict_set, evict_way};
  assign drop_idx = {drop_set,  drop_way};

  sf_vec_array #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_vec (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_idx    (req_idx),
    .req_core   (req_core),
    .req_own    (req_own),
    .req_hit    (lookup_hit),
    .drop_valid (drop_valid),
    .drop_idx   (drop_idx),
    .drop_core  (drop_core),
    .ev_valid   (evict_valid),
    .ev_idx     (ev_idx),
    .req_rd     (req_rd_vec),
    .ev_rd      (ev_rd_vec)
  );

  sf_req_path u_req (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_core    (req_core),
    .req_hit     (lookup_hit),
    .cur_vec     (req_rd_vec),
    .rsp_valid   (rsp_valid),
    .snoop_mask  (snoop_mask),
    .no_mod_hint (no_mod_hint)
  );

  sf_binv_path u_binv (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev_valid   (evict_valid),
    .ev_vec     (ev_rd_vec),
    .binv_valid (binv_valid),
    .binv_mask  (binv_mask)
  );
endmodule

// File: rtl/sf_checker.sv
module sf_checker
  import sf_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input cid_t req_core,
  input logic lookup_hit,
  input logic evict_valid,
  input logic rsp_valid,
  input cv_t  snoop_mask,
  input logic no_mod_hint,
  input logic binv_valid,
  input cv_t  binv_mask,
  input cv_t  ev_rd_vec
);
  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R2
  AST_QUIET_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && snoop_mask == '0 && !no_mod_hint)); // R2
  AST_MISS_NO_SNOOP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !lookup_hit) |=> (snoop_mask == '0 && no_mod_hint)); // R3
  AST_SELF_EXCLUDED: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> !snoop_mask[$past(req_core)]); // R4
  AST_MULTI_NOT_MODIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $countones(snoop_mask) > 1) |-> no_mod_hint); // R5
  AST_BINV_FOLLOWS_EVICT: assert property (@(posedge clk) disable iff (!rst_n)
    evict_valid |=> binv_valid); // R8
  AST_BINV_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !evict_valid |=> (!binv_valid && binv_mask == '0)); // R8
  AST_BINV_MATCHES_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    evict_valid |=> (binv_mask == $past(ev_rd_vec))); // R8
endmodule

bind cv_snoop_filter sf_checker u_sf_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_core    (req_core),
  .lookup_hit  (lookup_hit),
  .evict_valid (evict_valid),
  .rsp_valid   (rsp_valid),
  .snoop_mask  (snoop_mask),
  .no_mod_hint (no_mod_hint),
  .binv_valid  (binv_valid),
  .binv_mask   (binv_mask),
  .ev_rd_vec   (ev_rd_vec)
);

// File: tb/test_cv_snoop_filter.sv
module test_cv_snoop_filter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [1:0] req_core = '0;
  logic [2:0] req_set = '0;
  logic [3:0] req_way = '0;
  logic       req_own = 1'b0;
  logic       lookup_hit = 1'b0;
  logic       evict_valid = 1'b0;
  logic [2:0] evict_set = '0;
  logic [3:0] evict_way = '0;
  logic       drop_valid = 1'b0;
  logic [1:0] drop_core = '0;
  logic [2:0] drop_set = '0;
  logic [3:0] drop_way = '0;
  logic       rsp_valid;
  logic [3:0] snoop_mask;
  logic       no_mod_hint;
  logic       binv_valid;
  logic [3:0] binv_mask;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [3:0] mdl [8][16];

  always #5 clk = ~clk;

  cv_snoop_filter i_cv_snoop_filter (.*);

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic idle_inputs();
    req_valid = 0; evict_valid = 0; drop_valid = 0;
  endtask

  // Holds the driven inputs for one edge, then returns at the next negedge.
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    idle_inputs();
  endtask

  function automatic int ones(input logic [3:0] v);
    return int'(v[0]) + int'(v[1]) + int'(v[2]) + int'(v[3]);
  endfunction

  function automatic logic [3:0] bitof(input logic [1:0] c);
    return 4'b0001 << c;
  endfunction

  // Request with expected outputs from the presence model, then model update.
  task automatic req_check(input logic [1:0] c, input logic [2:0] s, input logic [3:0] w,
                           input bit own, input bit hit, input string rq);
    logic [3:0] old, em;
    bit eh;
    old = mdl[s][w];
    em  = hit ? (old & ~bitof(c)) : 4'b0;
    eh  = !hit || (ones(old) != 1);
    req_valid = 1; req_core = c; req_set = s; req_way = w; req_own = own; lookup_hit = hit;
    step();
    chk(rsp_valid == 1'b1, {rq, " rsp_valid"}, int'(rsp_valid), 1);
    chk(snoop_mask == em, {rq, " snoop_mask"}, int'(snoop_mask), int'(em));
    chk(no_mod_hint == eh, {rq, " no_mod_hint"}, int'(no_mod_hint), int'(eh));
    if (!hit || own) mdl[s][w] = bitof(c);
    else             mdl[s][w] = old | bitof(c);
  endtask

  task automatic evict_check(input logic [2:0] s, input logic [3:0] w, input string rq);
    logic [3:0] em;
    em = mdl[s][w];
    evict_valid = 1; evict_set = s; evict_way = w;
    step();
    chk(binv_valid == 1'b1, {rq, " binv_valid"}, int'(binv_valid), 1);
    chk(binv_mask == em, {rq, " binv_mask"}, int'(binv_mask), int'(em));
    mdl[s][w] = 4'b0;
  endtask

  task automatic drop_line(input logic [1:0] c, input logic [2:0] s, input logic [3:0] w);
    drop_valid = 1; drop_core = c; drop_set = s; drop_way = w;
    step();
    chk(rsp_valid == 1'b0 && binv_valid == 1'b0, "R2 quiet during drop", int'({rsp_valid, binv_valid}), 0);
    mdl[s][w] = mdl[s][w] & ~bitof(c);
  endtask

  task automatic t_reset();
    chk(rsp_valid == 0 && snoop_mask == 0 && no_mod_hint == 0, "R1 request outputs after reset",
        int'({rsp_valid, snoop_mask, no_mod_hint}), 0);
    chk(binv_valid == 0 && binv_mask == 0, "R1 binv outputs after reset",
        int'({binv_valid, binv_mask}), 0);
    req_check(2'd1, 3'd0, 4'd0, 0, 1, "R1 empty vector after reset");
    step();
    chk(rsp_valid == 0 && snoop_mask == 0 && no_mod_hint == 0, "R2 idle cycle quiet",
        int'({rsp_valid, snoop_mask, no_mod_hint}), 0);
  endtask

  task automatic t_fill_and_share();
    req_check(2'd0, 3'd1, 4'd2, 0, 0, "R3 miss fill");
    req_check(2'd1, 3'd1, 4'd2, 0, 1, "R4 R5 single holder");
    req_check(2'd2, 3'd1, 4'd2, 0, 1, "R6 read hit keeps others");
    req_check(2'd3, 3'd1, 4'd2, 0, 1, "R4 three holders");
  endtask

  task automatic t_ownership();
    req_check(2'd1, 3'd1, 4'd2, 1, 1, "R7 ownership snoops others");
    req_check(2'd0, 3'd1, 4'd2, 0, 1, "R7 only owner left");
  endtask

  task automatic t_evict();
    evict_check(3'd1, 4'd2, "R8 back-invalidate");
    req_check(2'd2, 3'd1, 4'd2, 0, 1, "R8 vector cleared");
  endtask

  task automatic t_drop();
    req_check(2'd0, 3'd3, 4'd5, 0, 0, "R3 fill for drop");
    req_check(2'd2, 3'd3, 4'd5, 0, 1, "R6 add core2");
    req_check(2'd3, 3'd3, 4'd5, 0, 1, "R6 add core3");
    drop_line(2'd2, 3'd3, 4'd5);
    req_check(2'd1, 3'd3, 4'd5, 0, 1, "R9 drop clears one bit");
  endtask

  task automatic t_same_cycle();
    req_check(2'd0, 3'd4, 4'd7, 0, 0, "R3 fill for overlap");
    req_check(2'd1, 3'd4, 4'd7, 0, 1, "R6 add core1");
    // Read from core2 and shared-cache eviction on the same entry.
    req_valid = 1; req_core = 2'd2; req_set = 3'd4; req_way = 4'd7; req_own = 0; lookup_hit = 1;
    evict_valid = 1; evict_set = 3'd4; evict_way = 4'd7;
    step();
    chk(snoop_mask == 4'b0011, "R10 snoop uses old vector", int'(snoop_mask), 3);
    chk(binv_mask == 4'b0011, "R10 binv uses old vector", int'(binv_mask), 3);
    mdl[4][7] = 4'b0;
    req_check(2'd3, 3'd4, 4'd7, 0, 1, "R10 eviction overrides request");
    // Read from core1 and drop by core1 on the same entry.
    req_check(2'd0, 3'd5, 4'd1, 0, 0, "R3 fill for drop overlap");
    req_valid = 1; req_core = 2'd1; req_set = 3'd5; req_way = 4'd1; req_own = 0; lookup_hit = 1;
    drop_valid = 1; drop_core = 2'd1; drop_set = 3'd5; drop_way = 4'd1;
    step();
    chk(snoop_mask == 4'b0001, "R10 request sees old vector", int'(snoop_mask), 1);
    mdl[5][1] = 4'b0001;
    req_check(2'd2, 3'd5, 4'd1, 0, 1, "R10 drop applied after request");
  endtask

  task automatic t_sweep();
    logic [15:0] lf;
    lf = 16'hACE1;
    for (int s = 0; s < 8; s++)
      for (int w = 0; w < 16; w++)
        req_check(2'(s + w), 3'(s), 4'(w), 0, 0, "R11 fill every entry");
    for (int i = 0; i < 300; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      if (lf[15:13] == 3'b111) evict_check(lf[4:2], lf[8:5], "R11 random eviction");
      else req_check(lf[1:0], lf[4:2], lf[8:5], lf[9], lf[12:10] != 3'b000, "R11 random traffic");
    end
  endtask

  initial begin
    for (int s = 0; s < 8; s++)
      for (int w = 0; w < 16; w++)
        mdl[s][w] = 4'b0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_fill_and_share();
    t_ownership();
    t_evict();
    t_drop();
    t_same_cycle();
    t_sweep();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule